// File: doc/BRIEF.md
# Externally Clocked Pattern Playback Generator

This block holds a table of DAC codes written by a host and plays it back one code at a time. A new code is taken each time an external sample clock rises. That clock has no fixed relation to the system clock, so it is first brought into the system clock domain. The table is replayed without end. The number of entries replayed comes from a length register that the host can rewrite at runtime. A one-cycle marker pulse shows each pass through entry 0, so a scope or downstream logic can trigger on the start of the sequence.

The outputs drive a parallel DAC directly. After each new code is placed on the data pins, the block waits a set number of cycles and then drives the DAC chip-select low for a set number of cycles. The DAC loads its input register while the strobe is low. The strobe's rising edge moves the code into the DAC output register. While the host rewrites the table, it holds `load_active` high. This freezes playback and leaves the strobe idle. Playback starts again at entry 0 when `load_active` is released.

Top module: `pbgen_top`

## Requirements
- R1: During and right after reset, `dac_data` is 0, `dac_cs_n` is 1 and `wrap_marker` is 0. The playback index starts at entry 0 and the terminal index is 0, so the length behaves as 1.
- R2: `dac_data` carries bits [13:0] of the 16-bit stored entry. Bits [15:14] of the entry never appear on the data pins.
- R3: Each rising edge of `sample_clk` presents exactly one new code. With the default two synchronizer stages, the code appears on the third rising edge of `clk` after `sample_clk` rises. A falling edge of `sample_clk` changes nothing.
- R4: Writing length L with `len_wr_en` sets the terminal index to L-1. After that entry is presented, the next sample edge presents entry 0, and the cycle repeats without end. Lengths up to 1023 are supported.
- R5: `wrap_marker` goes high for exactly one cycle, in the same cycle that entry 0 is presented. It stays low for every other entry.
- R6: A written length of 0 acts as length 1. Entry 0 is presented on every sample edge, and the marker pulses on every sample edge.
- R7: The strobe sequence after each new code uses the defaults SETUP_CYC=2 and LOW_CYC=3.
  - `dac_cs_n` stays 1 during the update cycle and the cycle after it.
  - `dac_cs_n` is then 0 for exactly 3 cycles, starting at the second clock edge after the data update.
  - `dac_cs_n` then returns to 1.
  - `dac_data` does not change while `dac_cs_n` is 0.
- R8: While `load_active` is 1, sample edges are ignored. `dac_data` holds its value, `dac_cs_n` stays 1 and `wrap_marker` stays 0. The first sample edge after release presents entry 0 with a marker.
- R9: A write with `pat_wr_en` stores `pat_wr_data` at entry `pat_wr_addr`. Later playback of that entry shows the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_clk | input | 1 | External sample clock, asynchronous to clk |
| load_active | input | 1 | Holds playback idle while the table is updated |
| pat_wr_en | input | 1 | Pattern entry write strobe |
| pat_wr_addr | input | 10 | Entry index for a pattern write |
| pat_wr_data | input | 16 | Entry value; bits [15:14] are unused |
| len_wr_en | input | 1 | Length register write strobe |
| len_wr_val | input | 10 | Sequence length (0 acts as 1) |
| dac_data | output | 14 | Code presented to the DAC data pins |
| dac_cs_n | output | 1 | DAC chip-select strobe, active low |
| wrap_marker | output | 1 | One-cycle pulse when entry 0 is presented |

## Verification
The assertions check on every cycle that:
- the synchronized sample event never lasts two cycles;
- the data pins stay still while the strobe is low;
- the marker never lasts more than one cycle;
- a held load keeps the strobe high, the marker low and the data unchanged.

Only the bench scenarios can show the rest:
- the exact three-cycle latency from a sample edge;
- the wrap point for each sequence length;
- that length 0 acts as 1;
- that the upper entry bits are dropped;
- that playback restarts at entry 0 after a load, including a sweep of a 530-entry table.

// File: rtl/pbgen_pkg.sv
package pbgen_pkg;
   typedef enum logic [1:0] {
      STB_IDLE  = 2'd0,
      STB_SETUP = 2'd1,
      STB_LOW   = 2'd2
   } strobe_state_e;
endpackage

// File: rtl/pbgen_edge_sync.sv
module pbgen_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pbgen_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise_pulse = chain[STAGES-1] & ~last_q;

   // R3: one sample edge yields a single-cycle event
   assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/pbgen_pattern_store.sv
module pbgen_pattern_store #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   generate
      if (DEPTH < 1 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
         $error("pbgen_pattern_store: DEPTH out of range for ADDR_W");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && wr_addr <= LAST_ADDR) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pbgen_index_seq.sv
module pbgen_index_seq #(
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              hold,
   input  logic              len_wr_en,
   input  logic [ADDR_W-1:0] len_wr_val,
   output logic [ADDR_W-1:0] cur_idx
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] term_q;
   logic [ADDR_W-1:0] term_d;

   always_comb begin
      if (len_wr_val == '0)            term_d = '0;
      else if (len_wr_val - 1'b1 > LAST_ADDR) term_d = LAST_ADDR;
      else                             term_d = len_wr_val - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         term_q <= '0;
      else if (len_wr_en) term_q <= term_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cur_idx <= '0;
      else if (hold)              cur_idx <= '0;
      else if (step) begin
         if (cur_idx >= term_q)   cur_idx <= '0;
         else                     cur_idx <= cur_idx + 1'b1;
      end
   end

   // R8: hold always returns the index to entry 0
   assert_hold_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (cur_idx == '0));
endmodule

// File: rtl/pbgen_dac_strobe.sv
module pbgen_dac_strobe
   import pbgen_pkg::*;
#(
   parameter int SETUP_CYC = 2,
   parameter int LOW_CYC   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic hold,
   output logic cs_n
);
   generate
      if (SETUP_CYC < 1 || LOW_CYC < 1) begin : g_bad_timing
         $error("pbgen_dac_strobe: SETUP_CYC and LOW_CYC must be at least 1");
      end
   endgenerate

   localparam int MAX_CYC = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   strobe_state_e    st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= STB_IDLE;
         cnt_q <= '0;
         cs_n  <= 1'b1;
      end else if (hold) begin
         st_q  <= STB_IDLE;
         cnt_q <= '0;
         cs_n  <= 1'b1;
      end else if (go) begin
         st_q  <= STB_SETUP;
         cnt_q <= CNT_W'(SETUP_CYC - 1);
         cs_n  <= 1'b1;
      end else begin
         case (st_q)
            STB_SETUP: begin
               if (cnt_q == '0) begin
                  st_q  <= STB_LOW;
                  cnt_q <= CNT_W'(LOW_CYC - 1);
                  cs_n  <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            STB_LOW: begin
               if (cnt_q == '0) begin
                  st_q <= STB_IDLE;
                  cs_n <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               st_q <= STB_IDLE;
               cs_n <= 1'b1;
            end
         endcase
      end
   end

   // R7: a new code always restarts with the strobe high
   assert_go_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !hold) |=> cs_n);
endmodule

// File: rtl/pbgen_top.sv
module pbgen_top #(
   parameter int DATA_W      = 14,
   parameter int WORD_W      = 16,
   parameter int LEN_W       = 10,
   parameter int DEPTH       = 1024,
   parameter int SYNC_STAGES = 2,
   parameter int SETUP_CYC   = 2,
   parameter int LOW_CYC     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_clk,
   input  logic              load_active,
   input  logic              pat_wr_en,
   input  logic [LEN_W-1:0]  pat_wr_addr,
   input  logic [WORD_W-1:0] pat_wr_data,
   input  logic              len_wr_en,
   input  logic [LEN_W-1:0]  len_wr_val,
   output logic [DATA_W-1:0] dac_data,
   output logic              dac_cs_n,
   output logic              wrap_marker
);
   generate
      if (DATA_W > WORD_W) begin : g_bad_width
         $error("pbgen_top: DATA_W must not exceed WORD_W");
      end
   endgenerate

   logic              tick;
   logic              advance;
   logic [LEN_W-1:0]  cur_idx;
   logic [WORD_W-1:0] cur_word;

   pbgen_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (sample_clk),
      .rise_pulse (tick)
   );

   assign advance = tick & ~load_active;

   pbgen_pattern_store #(.WORD_W(WORD_W), .ADDR_W(LEN_W), .DEPTH(DEPTH)) i_store (
      .clk     (clk),
      .wr_en   (pat_wr_en),
      .wr_addr (pat_wr_addr),
      .wr_data (pat_wr_data),
      .rd_addr (cur_idx),
      .rd_data (cur_word)
   );

   pbgen_index_seq #(.ADDR_W(LEN_W), .DEPTH(DEPTH)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (advance),
      .hold       (load_active),
      .len_wr_en  (len_wr_en),
      .len_wr_val (len_wr_val),
      .cur_idx    (cur_idx)
   );

   pbgen_dac_strobe #(.SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC)) i_strobe (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (advance),
      .hold (load_active),
      .cs_n (dac_cs_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_data    <= '0;
         wrap_marker <= 1'b0;
      end else begin
         wrap_marker <= advance && (cur_idx == '0);
         if (advance) dac_data <= cur_word[DATA_W-1:0];
      end
   end

   // R7: data pins are still whenever the DAC strobe is low
   assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_cs_n |-> $stable(dac_data));
   // R5: the marker never lasts two cycles
   assert_marker_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_marker |=> !wrap_marker);
   // R8: a held load keeps the DAC side idle and frozen
   assert_load_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_active |=> (dac_cs_n && !wrap_marker && $stable(dac_data)));
endmodule

// File: tb/test_pbgen_top.sv
module test_pbgen_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_clk = 1'b0;
   logic        load_active = 1'b0;
   logic        pat_wr_en = 1'b0;
   logic [9:0]  pat_wr_addr = '0;
   logic [15:0] pat_wr_data = '0;
   logic        len_wr_en = 1'b0;
   logic [9:0]  len_wr_val = '0;
   logic [13:0] dac_data;
   logic        dac_cs_n;
   logic        wrap_marker;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pbgen_top i_pbgen_top (
      .clk(clk), .rst_n(rst_n), .sample_clk(sample_clk), .load_active(load_active),
      .pat_wr_en(pat_wr_en), .pat_wr_addr(pat_wr_addr), .pat_wr_data(pat_wr_data),
      .len_wr_en(len_wr_en), .len_wr_val(len_wr_val),
      .dac_data(dac_data), .dac_cs_n(dac_cs_n), .wrap_marker(wrap_marker)
   );

   function automatic logic [15:0] pat(input int a, input int salt);
      return 16'((a * 16'h2F3B) + 16'hC001 + salt * 16'h0101);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_table(input int len, input int salt);
      int n;
      n = (len == 0) ? 1 : len;
      @(negedge clk) load_active = 1'b1;
      for (int a = 0; a < n; a++) begin
         @(negedge clk);
         pat_wr_en = 1'b1; pat_wr_addr = 10'(a); pat_wr_data = pat(a, salt);
      end
      @(negedge clk);
      pat_wr_en = 1'b0; len_wr_en = 1'b1; len_wr_val = 10'(len);
      @(negedge clk);
      len_wr_en = 1'b0;
      @(negedge clk) load_active = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // one sample edge; expect entry exp_idx to be presented
   task automatic do_edge(input int exp_idx, input int salt);
      logic [13:0] e;
      e = pat(exp_idx, salt) & 16'h3FFF;
      @(negedge clk) sample_clk = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk(dac_data == e, "R2 R3 R4 code after sample edge", dac_data, e);
      chk(wrap_marker == (exp_idx == 0), "R5 marker on entry 0", wrap_marker, exp_idx == 0);
      chk(dac_cs_n == 1'b1, "R7 strobe high at update", dac_cs_n, 1);
      @(posedge clk); #1;
      chk(dac_cs_n == 1'b1, "R7 strobe high during setup", dac_cs_n, 1);
      chk(wrap_marker == 1'b0, "R5 marker single cycle", wrap_marker, 0);
      for (int c = 0; c < 3; c++) begin
         @(posedge clk); #1;
         chk(dac_cs_n == 1'b0, "R7 strobe low phase", dac_cs_n, 0);
      end
      chk(dac_data == e, "R7 data stable while strobe low", dac_data, e);
      @(posedge clk); #1;
      chk(dac_cs_n == 1'b1, "R7 strobe back high", dac_cs_n, 1);
      @(negedge clk) sample_clk = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      chk(dac_data == e && dac_cs_n, "R3 falling edge has no effect", dac_data, e);
   endtask

   task automatic play(input int len, input int edges, input int salt);
      int eff;
      eff = (len == 0) ? 1 : len;
      for (int k = 0; k < edges; k++) do_edge(k % eff, salt);
   endtask

   initial begin
      #(200000 * 8);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [13:0] held;
      repeat (3) @(negedge clk);
      chk(dac_data == 0, "R1 data in reset", dac_data, 0);
      chk(dac_cs_n == 1'b1, "R1 strobe in reset", dac_cs_n, 1);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(dac_data == 0 && dac_cs_n && !wrap_marker, "R1 state after reset", dac_data, 0);

      // R9 R4 R6: sweep of short lengths, each wrapping at least twice
      begin
         int lens [6] = '{1, 2, 3, 5, 7, 0};
         for (int i = 0; i < 6; i++) begin
            load_table(lens[i], i);
            play(lens[i], 2 * ((lens[i] == 0) ? 1 : lens[i]) + 1, i);
         end
      end

      // R8: load in the middle of a pass, sample edge during load is ignored
      load_table(5, 9);
      play(5, 3, 9);
      held = pat(2, 9) & 16'h3FFF;
      @(negedge clk) load_active = 1'b1;
      @(negedge clk) sample_clk = 1'b1;
      for (int c = 0; c < 8; c++) begin
         @(posedge clk); #1;
         chk(dac_data == held && dac_cs_n && !wrap_marker, "R8 outputs frozen in load",
             dac_data, held);
      end
      @(negedge clk) sample_clk = 1'b0;
      repeat (4) @(negedge clk);
      load_active = 1'b0;
      repeat (2) @(negedge clk);
      play(5, 6, 9);

      // R4 R9: full 530 entry table wraps after its last entry
      load_table(530, 3);
      play(530, 532, 3);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule